// File: doc/BRIEF.md
# Programmable Reference Divider With Output Select

This block divides a reference clock down to a comparison rate for a frequency synthesiser loop. A 4-bit ratio code picks one of fifteen even division ratios. Eight of them are the powers of two from 2 to 256, and seven follow a three-times-power-of-two series from 6 to 384. One code value is illegal and is ignored. The divided result is given in two forms. One is a single-cycle strobe at each terminal count. The other is a comparison clock with exactly 50% duty.

A single output pin carries one of three things: the undivided reference, the comparison clock, or a static high level. Two control bits, an enable and a select, choose between them. Those bits, and the ratio code, arrive already latched from a control interface outside this block. The block registers the two control bits locally. After reset they behave as if both were 1, so the comparison clock is on the pin until the first real values are taken in.

Top module: `refdiv_top`

## Requirements
- R1: Ratio codes 0 to 7 (`ratio_code[3]` = 0) divide by 2 << `ratio_code[2:0]`, that is 2, 4, 8, 16, 32, 64, 128 and 256.
- R2: Ratio codes 9 to 15 (`ratio_code[3]` = 1) divide by 3 << `ratio_code[2:0]`, that is 6, 12, 24, 48, 96, 192 and 384.
- R3: Code 8 is illegal. When it is applied, the divider keeps the last legal ratio it used.
- R4: A new ratio code is taken in only at a terminal count, meaning the cycle in which `cmp_stb` is 1. The period in progress always completes with the ratio it started with.
- R5: In every period of N cycles, `cmp_stb` is 1 for exactly one cycle, the last cycle of the period. `cmp_clk` is 1 for the first N/2 cycles and 0 for the last N/2 cycles.
- R6: Synchronous reset does three things. It restarts the count with `cmp_clk` = 1 and `cmp_stb` = 0. It loads the ratio of the code present during reset, or ratio 2 if that code is 8. It puts the output pin in comparison-clock mode whatever the enable and select inputs are.
- R7: With `out_en` = 1 and `out_sel` = 0, `ref_out` follows the reference clock `clk`.
- R8: With `out_en` = 1 and `out_sel` = 1, `ref_out` equals `cmp_clk`.
- R9: With `out_en` = 0, `ref_out` is held at 1 for either value of `out_sel`.
- R10: A change of `out_en` or `out_sel` reaches `ref_out` at the first rising edge of `clk` after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the divider counts its rising edges |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code | input | 4 | Division ratio code, already latched |
| out_en | input | 1 | Output pin enable; 0 holds the pin high |
| out_sel | input | 1 | Output pin source when enabled: 0 for the reference, 1 for the comparison clock |
| cmp_stb | output | 1 | One-cycle strobe at each terminal count |
| cmp_clk | output | 1 | Comparison clock, 50% duty |
| ref_out | output | 1 | Selected output pin |

## Verification
The bench walks every code and measures both the full period and the high time of the comparison clock. A decode error therefore shows up as a wrong period, and an error in the half-period compare shows up as a wrong duty. Code 8 is placed straight after the 256 ratio. A divider that decodes code 8 as a ratio, or drops to a default ratio, would show a period other than 256. The ratio is also changed three cycles into a 16-cycle period. A design that reloads at once would cut that period short and produce a runt pulse. The output pin is sampled in both clock phases: a mux that lets the reference through in static mode would show a low phase, and a mux that misses the reset default would show the clock while reset is held.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  localparam int CODE_W  = 4;
  localparam int RATIO_W = 9;

  typedef enum logic [1:0] {
    PIN_HIGH = 2'd0,
    PIN_REF  = 2'd1,
    PIN_CMP  = 2'd2
  } pin_mode_e;

  // The only rejected code: top bit set, lower bits clear.
  function automatic logic code_legal(input logic [CODE_W-1:0] c);
    return c != {1'b1, {(CODE_W-1){1'b0}}};
  endfunction

  // Binary series (2 << k) when the top bit is clear, triple series (3 << k) otherwise.
  function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [CODE_W-1:0] c);
    logic [RATIO_W-1:0] base;
    base = c[CODE_W-1] ? RATIO_W'(3) : RATIO_W'(2);
    return base << c[CODE_W-2:0];
  endfunction

endpackage

// File: rtl/refdiv_ratio_sel.sv
module refdiv_ratio_sel
  import refdiv_pkg::*;
#(
  parameter int CW        = CODE_W,
  parameter int RW        = RATIO_W,
  parameter int DEF_RATIO = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] code,
  input  logic          tc,
  output logic [RW-1:0] ratio_q,
  output logic [RW-1:0] ratio_d
);

  logic          legal;
  logic [RW-1:0] decoded;

  always_comb begin
    legal   = code_legal(code);
    decoded = code_to_ratio(code);
    if (rst)
      ratio_d = legal ? decoded : RW'(DEF_RATIO);
    else if (tc && legal)
      ratio_d = decoded;
    else
      ratio_d = ratio_q;
  end

  always_ff @(posedge clk) begin
    ratio_q <= ratio_d;
  end

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int RW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] ratio_q,
  input  logic [RW-1:0] ratio_d,
  output logic          tc,
  output logic          stb_q,
  output logic          half_q
);

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] cnt_d;

  always_comb begin
    tc    = (cnt_q == ratio_q - RW'(1));
    cnt_d = tc ? '0 : cnt_q + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      stb_q  <= 1'b0;
      half_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      stb_q  <= (cnt_d == ratio_d - RW'(1));
      half_q <= (cnt_d < (ratio_d >> 1));
    end
  end

endmodule

// File: rtl/refdiv_pinmux.sv
module refdiv_pinmux
  import refdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sel,
  input  logic cmp,
  output logic pin
);

  pin_mode_e mode_q;
  pin_mode_e mode_d;

  always_comb begin
    if (!en)      mode_d = PIN_HIGH;
    else if (sel) mode_d = PIN_CMP;
    else          mode_d = PIN_REF;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= PIN_CMP;
    else     mode_q <= mode_d;
  end

  always_comb begin
    case (mode_q)
      PIN_REF: pin = clk;
      PIN_CMP: pin = cmp;
      default: pin = 1'b1;
    endcase
  end

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int CW        = CODE_W,
  parameter int RW        = RATIO_W,
  parameter int DEF_RATIO = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ratio_code,
  input  logic          out_en,
  input  logic          out_sel,
  output logic          cmp_stb,
  output logic          cmp_clk,
  output logic          ref_out
);

  logic          tc;
  logic [RW-1:0] ratio_q;
  logic [RW-1:0] ratio_d;

  refdiv_ratio_sel #(.CW(CW), .RW(RW), .DEF_RATIO(DEF_RATIO)) ratio_i (
    .clk     (clk),
    .rst     (rst),
    .code    (ratio_code),
    .tc      (tc),
    .ratio_q (ratio_q),
    .ratio_d (ratio_d)
  );

  refdiv_counter #(.RW(RW)) count_i (
    .clk     (clk),
    .rst     (rst),
    .ratio_q (ratio_q),
    .ratio_d (ratio_d),
    .tc      (tc),
    .stb_q   (cmp_stb),
    .half_q  (cmp_clk)
  );

  refdiv_pinmux pin_i (
    .clk (clk),
    .rst (rst),
    .en  (out_en),
    .sel (out_sel),
    .cmp (cmp_clk),
    .pin (ref_out)
  );

endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk
  import refdiv_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int RW = RATIO_W
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] ratio_code,
  input logic          out_en,
  input logic          out_sel,
  input logic          cmp_stb,
  input logic          cmp_clk,
  input logic          ref_out,
  input logic [RW-1:0] ratio_q
);

  // R1
  legal_code_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_stb && code_legal(ratio_code)) |=> (ratio_q == code_to_ratio($past(ratio_code))));

  // R3
  illegal_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio_code == 4'b1000) |=> $stable(ratio_q));

  // R4
  no_midperiod_change_chk: assert property (@(posedge clk) disable iff (rst)
    !cmp_stb |=> $stable(ratio_q));

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_stb |=> !cmp_stb);

  // R5
  period_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_clk) |-> $past(cmp_stb));

  // R8
  cmp_on_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (out_en && out_sel) |=> (ref_out == cmp_clk));

  // R9
  static_high_chk: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> ref_out);

endmodule

bind refdiv_top refdiv_chk #(.CW(CW), .RW(RW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ratio_code (ratio_code),
  .out_en     (out_en),
  .out_sel    (out_sel),
  .cmp_stb    (cmp_stb),
  .cmp_clk    (cmp_clk),
  .ref_out    (ref_out),
  .ratio_q    (ratio_q)
);

// File: tb/refdiv_top_tb_top.sv
`timescale 1ns/1ps
module refdiv_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ratio_code = 4'd3;
  logic       out_en  = 1'b1;
  logic       out_sel = 1'b0;
  logic       cmp_stb, cmp_clk, ref_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  refdiv_top dut_i (
    .clk(clk), .rst(rst), .ratio_code(ratio_code),
    .out_en(out_en), .out_sel(out_sel),
    .cmp_stb(cmp_stb), .cmp_clk(cmp_clk), .ref_out(ref_out)
  );

  // {code, expected period}; code 8 follows the 256 ratio and must keep it.
  localparam logic [12:0] VEC [16] = '{
    {4'd0, 9'd2},   {4'd1, 9'd4},   {4'd2, 9'd8},   {4'd3, 9'd16},
    {4'd4, 9'd32},  {4'd5, 9'd64},  {4'd6, 9'd128}, {4'd7, 9'd256},
    {4'd8, 9'd256}, {4'd9, 9'd6},   {4'd10, 9'd12}, {4'd11, 9'd24},
    {4'd12, 9'd48}, {4'd13, 9'd96}, {4'd14, 9'd192}, {4'd15, 9'd384}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_stb();
    do @(negedge clk); while (!cmp_stb);
  endtask

  // Starts at a negedge with cmp_stb = 1; ends at the next such negedge.
  task automatic measure(output int period, output int high, input int skip, input logic [3:0] late_code);
    period = 0;
    high   = 0;
    do begin
      @(negedge clk);
      period++;
      if (cmp_clk) high++;
      if (skip > 0 && period == skip) ratio_code = late_code;
    end while (!cmp_stb);
  endtask

  task automatic phase_sample(output logic hi_ph, output logic lo_ph);
    @(posedge clk); #5 hi_ph = ref_out;
    @(negedge clk); #5 lo_ph = ref_out;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per, hi;
    logic ph, pl;
    // Reset state, with the pin inputs asking for the reference (R6).
    repeat (3) @(negedge clk);
    #5;
    check("R6 reset cmp_clk", int'(cmp_clk), 1);
    check("R6 reset cmp_stb", int'(cmp_stb), 0);
    check("R6 reset pin low phase", int'(ref_out), 1);
    @(negedge clk);
    rst = 1'b0;
    wait_stb();
    out_sel = 1'b1;
    measure(per, hi, 0, 4'd0);
    check("R6 ratio from code at reset", per, 16);
    check("R6 R5 duty after reset", hi, 8);

    // Table walk over all codes (R1, R2, R3, R5).
    foreach (VEC[i]) begin
      ratio_code = VEC[i][12:9];
      measure(per, hi, 0, 4'd0);
      if (VEC[i][12:9] == 4'd8) check("R3 illegal code period", per, int'(VEC[i][8:0]));
      else if (VEC[i][12]) check("R2 triple series period", per, int'(VEC[i][8:0]));
      else check("R1 binary series period", per, int'(VEC[i][8:0]));
      check("R5 high time", hi, int'(VEC[i][8:0]) / 2);
    end

    // Ratio change in mid period (R4).
    ratio_code = 4'd3;
    measure(per, hi, 0, 4'd0);
    check("R4 setup period", per, 16);
    measure(per, hi, 3, 4'd0);
    check("R4 period with late code", per, 16);
    measure(per, hi, 0, 4'd0);
    check("R4 new ratio next period", per, 2);
    check("R5 high time ratio 2", hi, 1);

    // Pin modes: ratio 2 makes the comparison clock toggle every cycle.
    out_en = 1'b1; out_sel = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      phase_sample(ph, pl);
      check("R7 reference high phase", int'(ph), 1);
      check("R7 reference low phase", int'(pl), 0);
    end
    out_sel = 1'b1;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #5;
      check("R8 pin equals cmp_clk", int'(ref_out), int'(cmp_clk));
    end
    out_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      phase_sample(ph, pl);
      check("R9 static high sel1", int'(ph & pl), 1);
    end
    out_sel = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      phase_sample(ph, pl);
      check("R9 static high sel0", int'(ph & pl), 1);
    end

    // Latency of the pin select (R10): change at a negedge, visible after the next rising edge.
    @(negedge clk);
    out_en = 1'b1;
    #5;
    check("R10 old mode before edge", int'(ref_out), 1);
    @(negedge clk); #5;
    check("R10 new mode after edge", int'(ref_out), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule